// File: doc/BRIEF.md
# DMA Request Front End with Channel Masking and Bus Handshake

This block sits at the front of a four-channel DMA controller. Each channel can be started by a hardware request pin or by a software request bit. A per-channel mask decides whether that channel may be served. When at least one unmasked channel is pending, the block asks the processor for the bus. Once the processor grants the bus, the block selects the highest-priority pending channel and acknowledges it. The block keeps that grant until the transfer engine signals the end of the cycle. It releases the bus once the served channel no longer requests.

Masks and software requests are changed through a small command-write port. One command code selects each operation: set or clear one software request, set or clear one mask, load all masks, clear all masks, and master clear. A status word holds two flags per channel. The terminal-count flags are sticky and are cleared by a status read. The request flags show live activity.

The controller is built around a four-state machine:
- `ST_IDLE` moves to `ST_REQ` when any unmasked channel is pending.
- `ST_REQ` holds the bus request. It moves to `ST_GRANT` when the acknowledge arrives while a channel is still pending, and latches the channel chosen in that cycle. It falls back to `ST_IDLE` if nothing is pending any more.
- `ST_GRANT` moves to `ST_RELEASE` on the cycle-done pulse.
- `ST_RELEASE` returns to `ST_IDLE` once the served channel has no unmasked request left.

A master clear or a reset forces `ST_IDLE` from any state.

Top module: `dma_req_front`

## Requirements
- R1: After reset, `hold_o` and `dack_o` are low, all terminal-count flags are zero, and all four masks are set, so asserted `dreq_i` lines raise no bus request.
- R2: A channel whose mask is set is never acknowledged and, if it is the only requester, `hold_o` stays low.
- R3: Command code 4 (master clear) acts like reset. It sets all masks, clears all software requests and terminal-count flags, and drops `hold_o` on the next clock edge.
- R4: Command code 1 changes only the mask of the channel in `wr_data_i[1:0]`. `wr_data_i[2]`=1 sets that mask and 0 clears it. The other three masks keep their values.
- R5: Command code 2 loads all masks from `wr_data_i[3:0]`, where bit n belongs to channel n. Command code 3 clears all four masks.
- R6: Command code 0 sets (`wr_data_i[2]`=1) or clears (0) the software request of channel `wr_data_i[1:0]`. An unmasked software request is served like a hardware request. It is cleared when that channel's cycle ends.
- R7: `hold_o` rises on the clock edge after an unmasked request appears. `dack_o` is one-hot and is nonzero only in `ST_GRANT` while `hlda_i` is high. There is no acknowledge while `hlda_i` is low.
- R8: When several unmasked channels are pending, the lowest-numbered one is granted first.
- R9: `stat_o[3:0]` holds the terminal-count flag of channels 0 to 3. A flag is set when `done_i` and `tc_i` are high together during that channel's grant. `stat_o[7:4]` shows, per channel, the OR of `dreq_i` and the software request, regardless of mask.
- R10: A `stat_rd_i` pulse clears all terminal-count flags on the next edge.
- R11: After `done_i`, `hold_o` stays high while the served channel's unmasked request remains. It falls on the edge after that request goes away.
- R12: Command codes 5, 6 and 7 change neither masks nor software requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NCH | Hardware request per channel |
| hlda_i | input | 1 | Bus acknowledge from the processor |
| done_i | input | 1 | End of the current transfer cycle |
| tc_i | input | 1 | Terminal count reached, sampled with `done_i` |
| wr_en_i | input | 1 | Command write strobe |
| wr_cmd_i | input | 3 | Command code |
| wr_data_i | input | NCH | Command operand |
| stat_rd_i | input | 1 | Status read strobe, clears terminal-count flags |
| hold_o | output | 1 | Bus request to the processor |
| dack_o | output | NCH | One-hot channel acknowledge |
| stat_o | output | 2*NCH | {request flags, terminal-count flags} |

## Verification
The bench builds the block with its default of four channels. At that size, every priority level, every single-mask target and whole-nibble mask patterns are all reachable. The scoreboard records the order in which grants are expected: lowest-numbered first, with masked channels skipped. It then compares that order against the acknowledges the block produces. Directed phases hold the bus acknowledge back, keep a request up past the cycle end, and issue master clear while a request is outstanding.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [2:0] {
        CMD_SWREQ   = 3'd0,
        CMD_MASK1   = 3'd1,
        CMD_MASKALL = 3'd2,
        CMD_CLRMASK = 3'd3,
        CMD_MCLR    = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_GRANT,
        ST_RELEASE
    } st_e;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_req_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [2:0]     wr_cmd_i,
    input  logic [NCH-1:0] wr_data_i,
    input  logic [NCH-1:0] sreq_clr_i,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] sreq_o,
    output logic           mclr_o
);

    logic [CH_W-1:0] sel_ch;
    logic            sel_set;
    logic [NCH-1:0]  sel_oh;

    assign sel_ch  = wr_data_i[CH_W-1:0];
    assign sel_set = wr_data_i[CH_W];
    assign mclr_o  = wr_en_i && (wr_cmd_i == CMD_MCLR);

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign sel_oh[g] = (sel_ch == CH_W'(g));
    end

    // mask register: reset and master clear disable every channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (mclr_o) begin
            mask_o <= '1;
        end else if (wr_en_i) begin
            if (wr_cmd_i == CMD_MASK1) begin
                mask_o <= sel_set ? (mask_o | sel_oh) : (mask_o & ~sel_oh);
            end else if (wr_cmd_i == CMD_MASKALL) begin
                mask_o <= wr_data_i;
            end else if (wr_cmd_i == CMD_CLRMASK) begin
                mask_o <= '0;
            end
        end
    end

    // software request bits: a write wins over the end-of-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreq_o <= '0;
        end else if (mclr_o) begin
            sreq_o <= '0;
        end else if (wr_en_i && (wr_cmd_i == CMD_SWREQ)) begin
            sreq_o <= sel_set ? ((sreq_o & ~sreq_clr_i) | sel_oh)
                              : ((sreq_o & ~sreq_clr_i) & ~sel_oh);
        end else begin
            sreq_o <= sreq_o & ~sreq_clr_i;
        end
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req_i,
    output logic            any_o,
    output logic [CH_W-1:0] idx_o
);

    assign any_o = |req_i;

    // scan downward so the lowest-numbered pending channel wins
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           rd_i,
    input  logic [NCH-1:0] set_i,
    output logic [NCH-1:0] tc_o
);

    // a read clears old flags; a flag set in the same cycle survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_o <= '0;
        end else if (clr_i) begin
            tc_o <= '0;
        end else begin
            tc_o <= (tc_o & ~{NCH{rd_i}}) | set_i;
        end
    end

endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
    import dma_req_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq_i,
    input  logic           hlda_i,
    input  logic           done_i,
    input  logic           tc_i,
    input  logic           wr_en_i,
    input  logic [2:0]     wr_cmd_i,
    input  logic [NCH-1:0] wr_data_i,
    input  logic           stat_rd_i,
    output logic           hold_o,
    output logic [NCH-1:0] dack_o,
    output logic [2*NCH-1:0] stat_o
);

    st_e             state_q, state_d;
    logic [CH_W-1:0] gnt_q;
    logic [CH_W-1:0] pick_idx;
    logic            pick_any;
    logic [NCH-1:0]  mask;
    logic [NCH-1:0]  sreq;
    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  gnt_oh;
    logic [NCH-1:0]  tc_flags;
    logic [NCH-1:0]  cyc_end;
    logic            mclr;

    dma_cmd_decode #(.NCH(NCH)) cmd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_cmd_i   (wr_cmd_i),
        .wr_data_i  (wr_data_i),
        .sreq_clr_i (cyc_end),
        .mask_o     (mask),
        .sreq_o     (sreq),
        .mclr_o     (mclr)
    );

    assign pend = (dreq_i | sreq) & ~mask;

    dma_prio_pick #(.NCH(NCH)) pick_i (
        .req_i (pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_oh
        assign gnt_oh[g] = (gnt_q == CH_W'(g));
    end

    assign cyc_end = (state_q == ST_GRANT && done_i) ? gnt_oh : '0;

    dma_tc_status #(.NCH(NCH)) stat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (mclr),
        .rd_i  (stat_rd_i),
        .set_i (tc_i ? cyc_end : '0),
        .tc_o  (tc_flags)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pick_any) state_d = ST_REQ;
            ST_REQ:     if (!pick_any) state_d = ST_IDLE;
                        else if (hlda_i) state_d = ST_GRANT;
            ST_GRANT:   if (done_i) state_d = ST_RELEASE;
            ST_RELEASE: if (!pend[gnt_q]) state_d = ST_IDLE;
        endcase
    end

    // state register and latched grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
        end else if (mclr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REQ && hlda_i && pick_any) begin
                gnt_q <= pick_idx;
            end
        end
    end

    // outputs
    always_comb begin
        hold_o = (state_q != ST_IDLE);
        dack_o = (state_q == ST_GRANT && hlda_i) ? gnt_oh : '0;
        stat_o = {dreq_i | sreq, tc_flags};
    end

endmodule

// File: rtl/dma_req_front_chk.sv
module dma_req_front_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hlda_i,
    input logic           tc_i,
    input logic           stat_rd_i,
    input logic           wr_en_i,
    input logic [2:0]     wr_cmd_i,
    input logic           hold_o,
    input logic [NCH-1:0] dack_o,
    input logic [NCH-1:0] tc_flags
);

    logic mclr_seen;
    assign mclr_seen = wr_en_i && (wr_cmd_i == 3'd4);

    // R7: acknowledge is one-hot
    p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_o));

    // R7: acknowledge only under bus acknowledge and bus request
    p_dack_needs_hlda_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_o) |-> (hlda_i && hold_o));

    // R7: bus request precedes any acknowledge
    p_hold_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dack_o) |-> $past(hold_o));

    // R3: master clear drops the bus request and clears flags
    p_mclr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_seen |=> (!hold_o && tc_flags == '0));

    // R10: a status read clears terminal-count flags
    p_tc_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !tc_i && !mclr_seen) |=> (tc_flags == '0));

    // R11: the bus is never released mid-acknowledge except by master clear
    p_release_after_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> (!$past(|dack_o) || $past(mclr_seen)));

endmodule

bind dma_req_front dma_req_front_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hlda_i    (hlda_i),
    .tc_i      (tc_i),
    .stat_rd_i (stat_rd_i),
    .wr_en_i   (wr_en_i),
    .wr_cmd_i  (wr_cmd_i),
    .hold_o    (hold_o),
    .dack_o    (dack_o),
    .tc_flags  (stat_o[NCH-1:0])
);

// File: tb/dma_req_front_tb_top.sv
`timescale 1ns/1ps
module dma_req_front_tb_top;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] dreq_i = '0;
    logic           hlda_i = 1'b0;
    logic           done_i = 1'b0;
    logic           tc_i = 1'b0;
    logic           wr_en_i = 1'b0;
    logic [2:0]     wr_cmd_i = '0;
    logic [NCH-1:0] wr_data_i = '0;
    logic           stat_rd_i = 1'b0;
    logic           hold_o;
    logic [NCH-1:0] dack_o;
    logic [2*NCH-1:0] stat_o;

    int  n_chk = 0;
    int  n_fail = 0;
    int  exp_q[$];
    bit  auto_ack = 1'b1;
    logic [NCH-1:0] prev_dack = '0;

    always #2 clk = ~clk;

    dma_req_front #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .dreq_i(dreq_i), .hlda_i(hlda_i),
        .done_i(done_i), .tc_i(tc_i), .wr_en_i(wr_en_i), .wr_cmd_i(wr_cmd_i),
        .wr_data_i(wr_data_i), .stat_rd_i(stat_rd_i), .hold_o(hold_o),
        .dack_o(dack_o), .stat_o(stat_o)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // processor model: acknowledges the bus one half-cycle after the request
    initial forever begin
        @(negedge clk);
        hlda_i = auto_ack ? hold_o : 1'b0;
    end

    // scoreboard monitor: each new acknowledge must match the queue head
    initial forever begin
        @(negedge clk);
        if (rst_n && dack_o != '0 && prev_dack == '0) begin
            if (exp_q.size() == 0) begin
                check_eq("R2 R8 unexpected grant", int'(dack_o), 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check_eq("R7 R8 grant order", int'(dack_o), 1 << e);
            end
        end
        prev_dack = dack_o;
    end

    task automatic wr(input logic [2:0] cmd, input logic [NCH-1:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_cmd_i = cmd; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic serve(input int ch, input bit tcv, input bit drop);
        int w;
        w = 0;
        while (dack_o == '0 && w < 50) begin
            @(negedge clk);
            w++;
        end
        if (w >= 50) check_eq("R7 acknowledge timeout", 0, 1);
        @(negedge clk);
        done_i = 1'b1; tc_i = tcv;
        @(negedge clk);
        done_i = 1'b0; tc_i = 1'b0;
        if (drop) dreq_i[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        check_eq("watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 hold after reset", int'(hold_o), 0);
        check_eq("R1 dack after reset", int'(dack_o), 0);
        check_eq("R1 status after reset", int'(stat_o), 0);
        dreq_i = 4'b1111;
        repeat (5) @(negedge clk);
        check_eq("R1 masks set at reset", int'(hold_o), 0);
        check_eq("R9 live request flags", int'(stat_o[7:4]), 4'hF);

        // R4: single-channel unmask of channel 2 only
        wr(3'd1, 4'b0010);
        exp_q.push_back(2);
        serve(2, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check_eq("R4 R2 other masks unchanged", int'(hold_o), 0);

        // R5 clear-all, R8 priority among 0,1,3
        wr(3'd3, 4'b0000);
        exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(3);
        serve(0, 1'b0, 1'b1);
        serve(1, 1'b0, 1'b1);
        serve(3, 1'b0, 1'b1);
        dreq_i = 4'b0110;
        exp_q.push_back(1); exp_q.push_back(2);
        serve(1, 1'b0, 1'b1);
        serve(2, 1'b0, 1'b1);

        // R4: set one mask back, others stay clear
        wr(3'd1, 4'b0101);
        dreq_i = 4'b0010;
        repeat (4) @(negedge clk);
        check_eq("R4 mask set on channel 1", int'(hold_o), 0);
        dreq_i = 4'b0000;
        wr(3'd1, 4'b0001);

        // R7: no acknowledge until bus acknowledge
        auto_ack = 1'b0;
        dreq_i = 4'b0001;
        repeat (3) @(negedge clk);
        check_eq("R7 hold raised", int'(hold_o), 1);
        check_eq("R7 no dack before hlda", int'(dack_o), 0);
        exp_q.push_back(0);
        auto_ack = 1'b1;
        serve(0, 1'b0, 1'b1);

        // R11: bus kept while served request persists
        dreq_i = 4'b1000;
        exp_q.push_back(3);
        serve(3, 1'b0, 1'b0);
        check_eq("R11 hold kept with request", int'(hold_o), 1);
        dreq_i[3] = 1'b0;
        @(negedge clk);
        check_eq("R11 hold dropped", int'(hold_o), 0);

        // R6: software request on channel 2
        wr(3'd0, 4'b0110);
        exp_q.push_back(2);
        serve(2, 1'b0, 1'b1);
        check_eq("R6 hold idle after soft cycle", int'(hold_o), 0);
        check_eq("R6 soft request cleared", int'(stat_o[7:4]), 0);

        // R9: terminal count flag
        dreq_i = 4'b0010;
        exp_q.push_back(1);
        serve(1, 1'b1, 1'b1);
        check_eq("R9 tc flag channel 1", int'(stat_o[3:0]), 4'b0010);
        check_eq("R9 request flags idle", int'(stat_o[7:4]), 0);

        // R10: read clears
        @(negedge clk); stat_rd_i = 1'b1;
        @(negedge clk); stat_rd_i = 1'b0;
        check_eq("R10 tc cleared by read", int'(stat_o[3:0]), 0);

        // R12: unused codes
        wr(3'd5, 4'hF); wr(3'd6, 4'hF); wr(3'd7, 4'hF);
        check_eq("R12 no soft request", int'(stat_o[7:4]), 0);
        dreq_i = 4'b0001;
        exp_q.push_back(0);
        serve(0, 1'b1, 1'b1);
        check_eq("R12 masks intact, tc set", int'(stat_o[3:0]), 4'b0001);

        // R3: master clear with request outstanding
        auto_ack = 1'b0;
        dreq_i = 4'b0010;
        repeat (3) @(negedge clk);
        check_eq("R3 hold before clear", int'(hold_o), 1);
        wr(3'd0, 4'b0111);
        wr(3'd4, 4'b0000);
        check_eq("R3 hold dropped", int'(hold_o), 0);
        check_eq("R3 tc cleared", int'(stat_o[3:0]), 0);
        check_eq("R3 soft request cleared", int'(stat_o[7:4]), 4'b0010);
        repeat (4) @(negedge clk);
        check_eq("R3 masks set", int'(hold_o), 0);

        // R5: load all masks, channel 1 enabled
        wr(3'd2, 4'b1101);
        auto_ack = 1'b1;
        exp_q.push_back(1);
        serve(1, 1'b0, 1'b1);
        check_eq("R5 write-all enabled channel 1", int'(hold_o), 0);

        check_eq("R8 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule